// File: doc/BRIEF.md
# Widening Vector-by-Scalar Element Arithmetic Unit

This unit performs one widening integer operation per element. A vector element of SEW bits is combined with a scalar operand taken at 2*SEW bits, and the unit returns a 2*SEW-bit result. Addition, subtraction and multiplication are supported, in signed and unsigned form. With a wide scalar operand, a widening operation behaves like the non-widening operation at twice the element width. Software therefore needs no element-width switch around it.

The scalar register value is captured when an instruction begins and is reused for every element that follows. Each element is offered with a valid and a ready signal and comes back with a one-cycle result strobe. Multiplication is split into two parts. The first is a SEW x SEW product of the element and the low scalar half. The second is a truncated correction that adds the element times the high scalar half into the upper half of the result. The correction step costs one extra cycle, and it is skipped when the high scalar half carries no information.

Top module: `wmac_unit`

## Requirements
- R1: Only the low 2*SEW bits of the latched scalar take part in any operation; scalar bits above 2*SEW have no effect on the result.
- R2: The SEW-bit element (the low SEW bits of `vec_elem`) is zero-extended to 2*SEW when `is_signed`=0 and sign-extended when `is_signed`=1.
- R3: `op_sel`=2'b00 returns (extended element + scalar) mod 2^(2*SEW); `op_sel`=2'b01 returns (extended element − scalar) mod 2^(2*SEW).
- R4: `op_sel`=2'b10 returns (extended element × scalar) mod 2^(2*SEW), the product truncated to 2*SEW bits.
- R5: For multiplication, the result appears 1 cycle after acceptance when the upper SEW bits of the scalar are all zero (unsigned) or equal the sign extension of scalar bit SEW−1 (signed), and 2 cycles after acceptance otherwise, with the same value either way.
- R6: `in_ready` is high only while the unit is idle; `out_valid` is a single-cycle strobe per accepted element, and all operations other than a non-skipped multiply complete in 1 cycle.
- R7: An element with `mask_bit`=0 returns `old_dest` unchanged after 1 cycle, whatever the operation.
- R8: `op_sel`=2'b11 returns zero, and an unsupported `sew_sel` (3, or 2 when XLEN is 32) returns zero, each after 1 cycle.
- R9: `scalar_in` is captured only in a cycle with `instr_start`=1, and that value is used from that cycle on until the next start pulse.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.
- R11: `sew_sel` selects SEW as 0→8, 1→16, 2→32 (the last only when XLEN=64); result bits at 2*SEW and above are zero for active elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_start | input | 1 | Capture `scalar_in` for a new instruction |
| scalar_in | input | XLEN | Scalar register value |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Unit idle, element accepted this cycle if offered |
| vec_elem | input | XLEN/2 | Vector element, low SEW bits used |
| sew_sel | input | 2 | Element width code |
| op_sel | input | 2 | 00 add, 01 subtract, 10 multiply, 11 reserved |
| is_signed | input | 1 | Signed variant |
| mask_bit | input | 1 | Element active when 1 |
| old_dest | input | XLEN | Prior destination value for masked-off elements |
| out_valid | output | 1 | Result strobe |
| out_result | output | XLEN | Widened result |

## Verification
Random elements, scalars and widths are mixed with directed cases. Scalars carry random bits above 2*SEW, which separates correct scalar narrowing from use of the full register. The directed multiply cases use a high scalar half that is zero, one that is all ones paired with a set sign bit, and nonzero halves in both signednesses. These cases separate a correct skip decision, which shows in the latency, from a wrong one, which shows as a value or latency error. Subtract underflow, the reserved operation, an unsupported width, masked-off elements, and elements sent after `scalar_in` changes without a start pulse cover the remaining paths. The last case shows whether the latched scalar is honoured.

// File: rtl/wmac_pkg.sv
// Shared types for the widening element unit.
// Assumes op_sel encodings fixed by the instruction decoder.
package wmac_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_RSV = 2'b11
    } wmac_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HI   = 1'b1
    } wmac_state_e;
endpackage

// File: rtl/wmac_lane.sv
// Per-width operand preparation and multiply halves for one SEW value W.
// Produces the extended element, the scalar narrowed to 2W bits, the
// narrow product with a signed/unsigned low half, the truncated high-half
// correction already shifted by W, the 2W result mask and the skip flag.
// Assumes 2W <= OW; all outputs are zero above bit 2W-1.
module wmac_lane #(
    parameter int XLEN = 64,
    parameter int MW   = 32,
    parameter int W    = 8
) (
    input  logic [MW-1:0]   vec_raw,
    input  logic [XLEN-1:0] scal,
    input  logic            is_signed,
    output logic [2*MW-1:0] ext_o,
    output logic [2*MW-1:0] scal_o,
    output logic [2*MW-1:0] prod_o,
    output logic [2*MW-1:0] corr_o,
    output logic [2*MW-1:0] mask_o,
    output logic            skip_o
);
    localparam int W2 = 2 * W;
    localparam int OW = 2 * MW;

    logic [W-1:0]          v, s_lo, s_hi, s_hi_adj, corr;
    logic                  v_sgn, s_sgn;
    logic signed [W:0]     va, sa;
    logic signed [W2+1:0]  prod_full;

    // Split operands and derive sign bits used by the signed variants.
    always_comb begin
        v        = vec_raw[W-1:0];
        s_lo     = scal[W-1:0];
        s_hi     = scal[W2-1:W];
        v_sgn    = is_signed & v[W-1];
        s_sgn    = is_signed & s_lo[W-1];
        va       = {v_sgn, v};
        sa       = {s_sgn, s_lo};
        // High half re-based so the low half can be treated as signed.
        s_hi_adj = s_hi + {{(W-1){1'b0}}, s_sgn};
    end

    // First step: narrow SEW x SEW product, low half signed when requested.
    assign prod_full = va * sa;

    // Second step term: only the low W bits of element x high half matter.
    assign corr = v * s_hi_adj;

    assign ext_o  = OW'({{W{v_sgn}}, v});
    assign scal_o = OW'(scal[W2-1:0]);
    assign prod_o = OW'(prod_full[W2-1:0]);
    assign corr_o = OW'({corr, {W{1'b0}}});
    assign mask_o = OW'({W2{1'b1}});
    assign skip_o = (s_hi_adj == '0);
endmodule

// File: rtl/wmac_opmux.sv
// Single-cycle result for add, subtract, narrow multiply and reserved op.
// Assumes operands are already confined to 2*SEW bits; wraps via mask.
module wmac_opmux
    import wmac_pkg::*;
#(
    parameter int OW = 64
) (
    input  logic [OW-1:0] ext_v,
    input  logic [OW-1:0] scal_v,
    input  logic [OW-1:0] prod_v,
    input  logic [OW-1:0] mask_v,
    input  wmac_op_e      op,
    output logic [OW-1:0] res
);
    // Select the first-step result for the requested operation.
    always_comb begin
        unique case (op)
            OP_ADD:  res = (ext_v + scal_v) & mask_v;
            OP_SUB:  res = (ext_v - scal_v) & mask_v;
            OP_MUL:  res = prod_v;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/wmac_unit.sv
// Widening vector-by-scalar element unit (top).
// Latches the scalar on instr_start, accepts one element when idle and
// returns a 2*SEW result after 1 cycle, or 2 cycles for a multiply whose
// high scalar half is significant. Assumes XLEN is 32 or 64.
module wmac_unit
    import wmac_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_start,
    input  logic [XLEN-1:0]   scalar_in,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [XLEN/2-1:0] vec_elem,
    input  logic [1:0]        sew_sel,
    input  logic [1:0]        op_sel,
    input  logic              is_signed,
    input  logic              mask_bit,
    input  logic [XLEN-1:0]   old_dest,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_result
);
    localparam int MW   = XLEN / 2;
    localparam int OW   = XLEN;
    localparam int NSEW = $clog2(XLEN) - 3;

    wmac_state_e     state_q;
    logic [XLEN-1:0] scal_q, scal_eff;
    logic [OW-1:0]   res_q, corr_q, mask_q;
    logic            valid_q;

    logic [OW-1:0]   ext_a [NSEW];
    logic [OW-1:0]   scal_a[NSEW];
    logic [OW-1:0]   prod_a[NSEW];
    logic [OW-1:0]   corr_a[NSEW];
    logic [OW-1:0]   mask_a[NSEW];
    logic [NSEW-1:0] skip_a;

    logic [OW-1:0]   ext_s, scal_s, prod_s, corr_s, mask_s, op_res;
    logic            skip_s, sew_ok, accept;
    wmac_op_e        op_e;

    // A start pulse in the same cycle as an element supplies its scalar.
    assign scal_eff = instr_start ? scalar_in : scal_q;
    assign op_e     = wmac_op_e'(op_sel);
    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid & in_ready;
    assign sew_ok   = (int'(sew_sel) < NSEW);

    // One lane per supported element width.
    for (genvar g = 0; g < NSEW; g++) begin : g_lane
        wmac_lane #(.XLEN(XLEN), .MW(MW), .W(8 << g)) u_lane (
            .vec_raw  (vec_elem),
            .scal     (scal_eff),
            .is_signed(is_signed),
            .ext_o    (ext_a[g]),
            .scal_o   (scal_a[g]),
            .prod_o   (prod_a[g]),
            .corr_o   (corr_a[g]),
            .mask_o   (mask_a[g]),
            .skip_o   (skip_a[g])
        );
    end

    // Pick the lane that matches the requested width.
    always_comb begin
        ext_s  = '0;
        scal_s = '0;
        prod_s = '0;
        corr_s = '0;
        mask_s = '0;
        skip_s = 1'b1;
        for (int i = 0; i < NSEW; i++) begin
            if (int'(sew_sel) == i) begin
                ext_s  = ext_a[i];
                scal_s = scal_a[i];
                prod_s = prod_a[i];
                corr_s = corr_a[i];
                mask_s = mask_a[i];
                skip_s = skip_a[i];
            end
        end
    end

    wmac_opmux #(.OW(OW)) u_opmux (
        .ext_v (ext_s),
        .scal_v(scal_s),
        .prod_v(prod_s),
        .mask_v(mask_s),
        .op    (op_e),
        .res   (op_res)
    );

    // Scalar capture at instruction start.
    always_ff @(posedge clk) begin
        if (!rst_n) scal_q <= '0;
        else if (instr_start) scal_q <= scalar_in;
    end

    // Element sequencing: first step on accept, optional correction step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
            corr_q  <= '0;
            mask_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!mask_bit) begin
                            res_q   <= old_dest;
                            valid_q <= 1'b1;
                        end else if (!sew_ok) begin
                            res_q   <= '0;
                            valid_q <= 1'b1;
                        end else begin
                            res_q  <= op_res;
                            corr_q <= corr_s;
                            mask_q <= mask_s;
                            if (op_e == OP_MUL && !skip_s) state_q <= ST_HI;
                            else valid_q <= 1'b1;
                        end
                    end
                end
                ST_HI: begin
                    res_q   <= (res_q + corr_q) & mask_q;
                    valid_q <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign out_valid  = valid_q;
    assign out_result = res_q;
endmodule

// File: rtl/wmac_unit_chk.sv
// Port-level properties of wmac_unit, attached by bind.
module wmac_unit_chk #(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        sew_sel,
    input logic [1:0]        op_sel,
    input logic              mask_bit,
    input logic [XLEN-1:0]   old_dest,
    input logic              out_valid,
    input logic [XLEN-1:0]   out_result
);
    AST_BUSY_ENDS_IN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (out_valid && in_ready)); // R5
    AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid && in_ready) || $past(!in_ready))); // R6
    AST_MASKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !mask_bit) |=> (out_valid && out_result == $past(old_dest))); // R7
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && mask_bit && op_sel == 2'b11) |=> (out_valid && out_result == '0)); // R8
    AST_SEW8_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && mask_bit && sew_sel == 2'd0 && op_sel != 2'b10)
        |=> (out_result[XLEN-1:16] == '0)); // R11
endmodule

bind wmac_unit wmac_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sew_sel   (sew_sel),
    .op_sel    (op_sel),
    .mask_bit  (mask_bit),
    .old_dest  (old_dest),
    .out_valid (out_valid),
    .out_result(out_result)
);

// File: tb/wmac_unit_tb.sv
module wmac_unit_tb;
    localparam int XLEN = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_start = 1'b0;
    logic [XLEN-1:0]   scalar_in = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [XLEN/2-1:0] vec_elem = '0;
    logic [1:0]        sew_sel = '0;
    logic [1:0]        op_sel = '0;
    logic              is_signed = 1'b0;
    logic              mask_bit = 1'b1;
    logic [XLEN-1:0]   old_dest = '0;
    logic              out_valid;
    logic [XLEN-1:0]   out_result;

    int tests = 0;
    int fails = 0;
    logic [63:0] exp_scal = '0;

    always #5 clk = ~clk;

    wmac_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .scalar_in(scalar_in),
        .in_valid(in_valid), .in_ready(in_ready), .vec_elem(vec_elem),
        .sew_sel(sew_sel), .op_sel(op_sel), .is_signed(is_signed),
        .mask_bit(mask_bit), .old_dest(old_dest), .out_valid(out_valid),
        .out_result(out_result)
    );

    function automatic logic [63:0] wmask(int sew);
        int w2 = 16 << sew;
        return (w2 >= 64) ? '1 : ((64'd1 << w2) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_res(logic [31:0] e, logic [63:0] s, int sew,
                                            int op, bit sg, bit m, logic [63:0] old);
        int w;
        logic [63:0] ev, sv, mk, lo;
        if (!m) return old;
        if (sew > 2) return '0;
        w  = 8 << sew;
        mk = wmask(sew);
        lo = (64'd1 << w) - 64'd1;
        ev = {32'd0, e} & lo;
        if (sg && ev[w-1]) ev = ev | ~lo;
        ev = ev & mk;
        sv = s & mk;
        case (op)
            0: return (ev + sv) & mk;
            1: return (ev - sv) & mk;
            2: return (ev * sv) & mk;
            default: return '0;
        endcase
    endfunction

    function automatic int ref_lat(logic [63:0] s, int sew, int op, bit sg, bit m);
        int w;
        logic [63:0] lo, hi;
        if (!m || sew > 2 || op != 2) return 1;
        w  = 8 << sew;
        lo = (64'd1 << w) - 64'd1;
        hi = (s >> w) & lo;
        if (sg && s[w-1]) return (hi == lo) ? 1 : 2;
        return (hi == 0) ? 1 : 2;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic start_instr(logic [63:0] s);
        @(negedge clk);
        instr_start = 1'b1;
        scalar_in   = s;
        exp_scal    = s;
        @(negedge clk);
        instr_start = 1'b0;
        scalar_in   = {$urandom, $urandom};
    endtask

    task automatic do_elem(logic [31:0] e, int sew, int op, bit sg, bit m,
                           logic [63:0] old, string req);
        logic [63:0] expv;
        int el, lat;
        expv = ref_res(e, exp_scal, sew, op, sg, m, old);
        el   = ref_lat(exp_scal, sew, op, sg, m);
        @(negedge clk);
        vec_elem = e; sew_sel = 2'(sew); op_sel = 2'(op);
        is_signed = sg; mask_bit = m; old_dest = old; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 5) begin
            // R6: busy unit must refuse new elements
            check(!in_ready, "R6 ready low while busy", 64'(in_ready), 64'd0);
            @(negedge clk);
            lat++;
        end
        check(out_result == expv, req, out_result, expv);
        check(lat == el, "R5 latency", 64'(lat), 64'(el));
        @(negedge clk);
        check(!out_valid, "R6 single strobe", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10: idle state during and after reset
        check(!out_valid && in_ready, "R10 reset state", {62'd0, out_valid, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R10 after reset", {62'd0, out_valid, in_ready}, 64'd1);

        // R1: garbage above 2*SEW, high half zero -> skip
        start_instr(64'hDEAD_BEEF_0000_00AB);
        do_elem(32'h0000_00F3, 0, 2, 1'b0, 1'b1, 0, "R1 scalar narrowed mul");
        do_elem(32'h0000_00F3, 0, 0, 1'b0, 1'b1, 0, "R1 scalar narrowed add");
        // R2: sign vs zero extension
        do_elem(32'h0000_0080, 0, 0, 1'b1, 1'b1, 0, "R2 sign extend");
        do_elem(32'h0000_0080, 0, 0, 1'b0, 1'b1, 0, "R2 zero extend");
        // R5: signed, high half pure sign extension -> skip
        start_instr(64'h0000_0000_0000_FFFF);
        do_elem(32'h0000_0080, 0, 2, 1'b1, 1'b1, 0, "R5 signed skip");
        do_elem(32'h0000_0080, 0, 2, 1'b0, 1'b1, 0, "R5 unsigned full");
        // R4/R5: nonzero high half in both signednesses
        start_instr(64'h0000_0000_0000_0100);
        do_elem(32'h0000_007F, 0, 2, 1'b1, 1'b1, 0, "R4 signed with correction");
        start_instr(64'hFFFF_FFFF_8765_4321);
        do_elem(32'h8000_0001, 2, 2, 1'b1, 1'b1, 0, "R4 sew32 signed");
        do_elem(32'hFFFF_FFFF, 2, 2, 1'b0, 1'b1, 0, "R4 sew32 unsigned");
        // R3: subtract underflow wraps
        start_instr(64'h0000_0000_0001_0000);
        do_elem(32'h0000_0001, 1, 1, 1'b0, 1'b1, 0, "R3 sub wrap sew16");
        // R8: reserved op and unsupported width
        do_elem(32'h0000_1234, 1, 3, 1'b0, 1'b1, 0, "R8 reserved op");
        do_elem(32'h0000_1234, 3, 0, 1'b0, 1'b1, 0, "R8 bad sew");
        // R7: masked-off passes old value, even for multiply
        start_instr(64'h0000_0000_FFFF_0001);
        do_elem(32'h0000_5555, 1, 2, 1'b0, 1'b0, 64'hCAFE_F00D_1234_5678, "R7 masked");
        // R9: scalar_in changes without start pulse
        start_instr(64'h0000_0000_0000_0305);
        scalar_in = 64'hFFFF_FFFF_FFFF_FFFF;
        do_elem(32'h0000_0011, 0, 2, 1'b0, 1'b1, 0, "R9 latched scalar used");
        do_elem(32'h0000_0022, 0, 0, 1'b0, 1'b1, 0, "R9 latched scalar add");

        // Random mix (R3 R4 R11 general)
        for (int n = 0; n < 400; n++) begin
            int sew, op;
            if (n % 8 == 0) start_instr({$urandom, $urandom});
            sew = $urandom_range(0, 2);
            op  = $urandom_range(0, 3);
            do_elem($urandom, sew, op, 1'($urandom), ($urandom_range(0, 7) != 0),
                    {$urandom, $urandom}, "R11 random op");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule